// File: doc/BRIEF.md
# Synthesizer Output and Test-Pin Dividers

This block produces the divided output clock of a frequency synthesizer and the signal shown on its test pin. Everything runs on one fast system clock. Each slower clock (the oscillator clock, the crystal reference and the serial configuration clock) arrives as a one-cycle tick that marks that clock's rising edge. Each divided clock leaves the block as a level on the system clock.

The block has three dividers. The first is a power-of-two output divider with an even duty cycle, selected by a 2-bit code. The second is a 9-bit programmable loop divider that emits a one-cycle pulse every M source ticks. The third is a fixed reference divider. A 3-bit test code picks one of eight internal nodes for the test pin. One code puts the block in bypass: the serial clock ticks then drive both the output divider and the loop divider in place of the oscillator ticks, which allows slow functional testing at board level. When the N code, the M value or the bypass state changes, the affected dividers restart from zero, so the output never shows a runt pulse.

Top module: `clk_synth_divider`

## Requirements
- R1: The main output gives one rising edge every 2, 4, 8 or 16 source ticks for an N code of 00, 01, 10 or 11.
- R2: The main output is high for half of each of its periods, measured in system-clock cycles when the ticks are evenly spaced.
- R3: With test code 011, the test pin gives one pulse, one system cycle wide, after every M source ticks, where M is the 9-bit unsigned value.
- R4: An M value of 0 or 1 divides by one: every source tick gives a test-pin pulse under code 011.
- R5: With test code 010, the test pin shows the reference ticks divided by 8, as one rising edge every 8 reference ticks.
- R6: Test code 001 holds the test pin high and code 101 holds it low, whatever the ticks do.
- R7: Test code 000 passes the shift-register last-bit input to the test pin.
- R8: Test code 100 copies the main output to the test pin; code 111 shows the main output divided by 4.
- R9: Test code 110 is bypass. Serial ticks drive both dividers, the test pin shows serial ticks divided by M, and oscillator ticks have no effect.
- R10: Under every code other than 110, the dividers are driven by oscillator ticks, and serial ticks have no effect on either divider.
- R11: A change of the N code or of the bypass state clears the output divider, and a change of M or of the bypass state clears the loop divider. Both are cleared at the first clock edge that sees the new value, and the main output is then low.
- R12: While reset is active, the main output and the loop-divider pulse are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rstN | input | 1 | Active-low synchronous reset |
| vcoTick | input | 1 | One-cycle tick for each oscillator clock edge |
| refTick | input | 1 | One-cycle tick for each crystal reference edge |
| serTick | input | 1 | One-cycle tick for each serial clock edge |
| nSel | input | 2 | Output divider code, ratio 2^(nSel+1) |
| mVal | input | 9 | Loop divider modulus |
| tSel | input | 3 | Test pin selector code |
| shiftLast | input | 1 | Last bit of the configuration shift register |
| fOut | output | 1 | Main divided output |
| testPin | output | 1 | Selected test node |

## Verification
Each divider's output register updates at the clock edge that samples the M-th tick, so a pulse or toggle shows in the cycle after that edge. The bench drives ticks at a falling edge and counts edges on the outputs at falling edges. It reads a scenario's totals only two cycles after the last tick, and only after a #1 offset. A configuration change clears the dividers at the next rising edge, so the bench waits three cycles after each change before it takes a starting snapshot. The restart check reads the main output exactly one edge after the change. The bypass and ignore checks count edges across a whole tick train, so a single stray edge shows up.

// File: rtl/clk_synth_pkg.sv
package clk_synth_pkg;

  // strobes from control to datapath
  typedef struct packed {
    logic srcTick;   // selected divider source tick
    logic refTick;   // reference tick
    logic clrOut;    // restart output divider
    logic clrLoop;   // restart loop divider
  } divStrobe_t;

  typedef enum logic [2:0] {
    TSEL_SHIFT  = 3'b000,
    TSEL_HIGH   = 3'b001,
    TSEL_FREF   = 3'b010,
    TSEL_LOOP   = 3'b011,
    TSEL_MAIN   = 3'b100,
    TSEL_LOW    = 3'b101,
    TSEL_BYPASS = 3'b110,
    TSEL_MAIN4  = 3'b111
  } testSel_e;

endpackage

// File: rtl/clk_synth_ctrl.sv
module clk_synth_ctrl
  import clk_synth_pkg::*;
#(
  parameter int M_W = 9,
  parameter int N_W = 2,
  parameter int T_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             vcoTick,
  input  logic             refTick,
  input  logic             serTick,
  input  logic [N_W-1:0]   nSel,
  input  logic [M_W-1:0]   mVal,
  input  logic [T_W-1:0]   tSel,
  output divStrobe_t       strb
);

  logic           bypass;
  logic           bypPrev;
  logic [N_W-1:0] nPrev;
  logic [M_W-1:0] mPrev;

  assign bypass = (tSel == T_W'(TSEL_BYPASS));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bypPrev <= 1'b0;
      nPrev   <= '0;
      mPrev   <= '0;
    end else begin
      bypPrev <= bypass;
      nPrev   <= nSel;
      mPrev   <= mVal;
    end
  end

  always_comb begin
    strb.srcTick = bypass ? serTick : vcoTick;
    strb.refTick = refTick;
    strb.clrOut  = (nSel != nPrev) || (bypass != bypPrev);
    strb.clrLoop = (mVal != mPrev) || (bypass != bypPrev);
  end

  // R9: in bypass an oscillator tick alone never reaches the dividers
  assert_bypass_blocks_vco_R9: assert property (@(posedge clk) disable iff (!rstN)
    (bypass && !serTick) |-> !strb.srcTick);

endmodule

// File: rtl/clk_synth_datapath.sv
module clk_synth_datapath
  import clk_synth_pkg::*;
#(
  parameter int M_W     = 9,
  parameter int N_W     = 2,
  parameter int T_W     = 3,
  parameter int REF_DIV = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  divStrobe_t       strb,
  input  logic [N_W-1:0]   nSel,
  input  logic [M_W-1:0]   mVal,
  input  logic [T_W-1:0]   tSel,
  input  logic             shiftLast,
  output logic             fOut,
  output logic             testPin
);

  localparam int OUT_CW   = 2 ** N_W;
  localparam int REF_HALF = REF_DIV / 2;
  localparam int REF_CW   = $clog2(REF_DIV);

  // output divider: toggles every 2^nSel source ticks
  logic [OUT_CW-1:0] outCnt;
  logic [OUT_CW-1:0] outLim;

  assign outLim = (OUT_CW'(1) << nSel) - OUT_CW'(1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outCnt <= '0;
      fOut   <= 1'b0;
    end else if (strb.clrOut) begin
      outCnt <= '0;
      fOut   <= 1'b0;
    end else if (strb.srcTick) begin
      if (outCnt >= outLim) begin
        outCnt <= '0;
        fOut   <= ~fOut;
      end else begin
        outCnt <= outCnt + OUT_CW'(1);
      end
    end
  end

  // main output divided by 4 (toggle every second rising edge)
  logic fOutPrev;
  logic q4Cnt;
  logic fOutQ4;
  logic fOutRise;

  assign fOutRise = fOut && !fOutPrev;

  always_ff @(posedge clk) begin
    if (!rstN || strb.clrOut) begin
      fOutPrev <= 1'b0;
      q4Cnt    <= 1'b0;
      fOutQ4   <= 1'b0;
    end else begin
      fOutPrev <= fOut;
      if (fOutRise) begin
        q4Cnt <= ~q4Cnt;
        if (q4Cnt) fOutQ4 <= ~fOutQ4;
      end
    end
  end

  // loop divider: one-cycle pulse every M source ticks
  logic [M_W-1:0] loopCnt;
  logic [M_W-1:0] mLim;
  logic           loopPulse;

  assign mLim = (mVal <= M_W'(1)) ? '0 : mVal - M_W'(1);

  always_ff @(posedge clk) begin
    if (!rstN || strb.clrLoop) begin
      loopCnt   <= '0;
      loopPulse <= 1'b0;
    end else begin
      loopPulse <= 1'b0;
      if (strb.srcTick) begin
        if (loopCnt >= mLim) begin
          loopCnt   <= '0;
          loopPulse <= 1'b1;
        end else begin
          loopCnt <= loopCnt + M_W'(1);
        end
      end
    end
  end

  // fixed reference divider
  logic [REF_CW-1:0] refCnt;
  logic              fRef;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      refCnt <= '0;
      fRef   <= 1'b0;
    end else if (strb.refTick) begin
      if (refCnt == REF_CW'(REF_HALF - 1)) begin
        refCnt <= '0;
        fRef   <= ~fRef;
      end else begin
        refCnt <= refCnt + REF_CW'(1);
      end
    end
  end

  // test pin selector
  always_comb begin
    case (testSel_e'(tSel))
      TSEL_SHIFT:  testPin = shiftLast;
      TSEL_HIGH:   testPin = 1'b1;
      TSEL_FREF:   testPin = fRef;
      TSEL_LOOP:   testPin = loopPulse;
      TSEL_MAIN:   testPin = fOut;
      TSEL_LOW:    testPin = 1'b0;
      TSEL_BYPASS: testPin = loopPulse;
      default:     testPin = fOutQ4;
    endcase
  end

  // R1: main output moves only on a source tick or a restart
  assert_fout_on_tick_R1: assert property (@(posedge clk) disable iff (!rstN)
    (fOut != $past(fOut)) |-> $past(strb.srcTick || strb.clrOut));

  // R3: a loop pulse follows a source tick and lasts one cycle
  assert_loop_pulse_R3: assert property (@(posedge clk) disable iff (!rstN)
    loopPulse |-> ($past(strb.srcTick) && !$past(loopPulse)));

  // R5: reference output moves only on a reference tick
  assert_fref_on_tick_R5: assert property (@(posedge clk) disable iff (!rstN)
    (fRef != $past(fRef)) |-> $past(strb.refTick));

  // R8: divide-by-4 node changes only after a main-output rise
  assert_q4_after_rise_R8: assert property (@(posedge clk) disable iff (!rstN)
    (fOutQ4 != $past(fOutQ4)) |-> ($past(fOut) || $past(strb.clrOut)));

  // R11: restart leaves both dividers low
  assert_restart_low_R11: assert property (@(posedge clk) disable iff (!rstN)
    (strb.clrOut || strb.clrLoop) |=> (!fOut || !$past(strb.clrOut)) && (!loopPulse || !$past(strb.clrLoop)));

endmodule

// File: rtl/clk_synth_divider.sv
module clk_synth_divider
  import clk_synth_pkg::*;
#(
  parameter int M_W     = 9,
  parameter int N_W     = 2,
  parameter int T_W     = 3,
  parameter int REF_DIV = 8
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           vcoTick,
  input  logic           refTick,
  input  logic           serTick,
  input  logic [N_W-1:0] nSel,
  input  logic [M_W-1:0] mVal,
  input  logic [T_W-1:0] tSel,
  input  logic           shiftLast,
  output logic           fOut,
  output logic           testPin
);

  divStrobe_t strb;

  clk_synth_ctrl #(.M_W(M_W), .N_W(N_W), .T_W(T_W)) i_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .vcoTick (vcoTick),
    .refTick (refTick),
    .serTick (serTick),
    .nSel    (nSel),
    .mVal    (mVal),
    .tSel    (tSel),
    .strb    (strb)
  );

  clk_synth_datapath #(.M_W(M_W), .N_W(N_W), .T_W(T_W), .REF_DIV(REF_DIV)) i_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .nSel      (nSel),
    .mVal      (mVal),
    .tSel      (tSel),
    .shiftLast (shiftLast),
    .fOut      (fOut),
    .testPin   (testPin)
  );

endmodule

// File: tb/test_clk_synth_divider.sv
module test_clk_synth_divider;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       vcoTick = 1'b0, refTick = 1'b0, serTick = 1'b0;
  logic [1:0] nSel = 2'd0;
  logic [8:0] mVal = 9'd5;
  logic [2:0] tSel = 3'b011;
  logic       shiftLast = 1'b0;
  logic       fOut, testPin;

  int nChecks = 0, nFails = 0;
  int fRise = 0, tRise = 0, fHi = 0, tHi = 0, samp = 0, mis = 0;
  logic fP = 1'b0, tP = 1'b0;

  always #2.5 clk = ~clk;

  clk_synth_divider i_clk_synth_divider (
    .clk(clk), .rstN(rstN), .vcoTick(vcoTick), .refTick(refTick), .serTick(serTick),
    .nSel(nSel), .mVal(mVal), .tSel(tSel), .shiftLast(shiftLast),
    .fOut(fOut), .testPin(testPin)
  );

  always @(negedge clk) begin
    if (fOut && !fP) fRise++;
    if (testPin && !tP) tRise++;
    if (fOut) fHi++;
    if (testPin) tHi++;
    if (testPin != fOut) mis++;
    samp++;
    fP = fOut;
    tP = testPin;
  end

  task automatic chk(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic ticks(input int kind, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (kind == 0) vcoTick = 1'b1; else if (kind == 1) refTick = 1'b1; else serTick = 1'b1;
      @(negedge clk);
      vcoTick = 1'b0; refTick = 1'b0; serTick = 1'b0;
    end
    repeat (2) @(negedge clk);
    #1;
  endtask

  task automatic setCfg(input logic [1:0] n, input logic [8:0] m, input logic [2:0] t);
    @(negedge clk);
    nSel = n; mVal = m; tSel = t;
    repeat (3) @(negedge clk);
    #1;
  endtask

  // passes through a different bypass state so both dividers restart
  task automatic freshCfg(input logic [1:0] n, input logic [8:0] m, input logic [2:0] t);
    setCfg(n, m, (t == 3'b110) ? 3'b001 : 3'b110);
    setCfg(n, m, t);
  endtask

  task automatic testReset();
    #1;
    chk("R12 fOut in reset", int'(fOut), 0);
    chk("R12 loop pulse in reset", int'(testPin), 0);
  endtask

  task automatic testOutRatio();
    for (int n = 0; n < 4; n++) begin
      int f0, h0, s0, hi, tot;
      freshCfg(2'(n), 9'd5, 3'b011);
      f0 = fRise; h0 = fHi; s0 = samp;
      ticks(0, 64);
      chk($sformatf("R1 rises N=%0d", n), fRise - f0, 64 >> (n + 1));
      hi = fHi - h0; tot = samp - s0;
      chk($sformatf("R2 duty N=%0d", n), (2 * hi >= tot - 4 && 2 * hi <= tot + 4) ? 1 : 0, 1);
    end
  endtask

  task automatic testLoop();
    int t0;
    freshCfg(2'd0, 9'd5, 3'b011);
    t0 = tRise; ticks(0, 40); chk("R3 M=5", tRise - t0, 8);
    freshCfg(2'd0, 9'd3, 3'b011);
    t0 = tRise; ticks(0, 31); chk("R3 M=3", tRise - t0, 10);
    freshCfg(2'd0, 9'd200, 3'b011);
    t0 = tRise; ticks(0, 450); chk("R3 M=200", tRise - t0, 2);
    freshCfg(2'd0, 9'd0, 3'b011);
    t0 = tRise; ticks(0, 20); chk("R4 M=0", tRise - t0, 20);
    freshCfg(2'd0, 9'd1, 3'b011);
    t0 = tRise; ticks(0, 17); chk("R4 M=1", tRise - t0, 17);
  endtask

  task automatic testRef();
    int t0;
    setCfg(2'd0, 9'd1, 3'b010);
    t0 = tRise; ticks(1, 64); chk("R5 ref div 8", tRise - t0, 8);
  endtask

  task automatic testConst();
    int h0, s0;
    setCfg(2'd0, 9'd1, 3'b001);
    h0 = tHi; s0 = samp; ticks(0, 16); ticks(1, 16);
    chk("R6 constant high", tHi - h0, samp - s0);
    setCfg(2'd0, 9'd1, 3'b101);
    h0 = tHi; ticks(0, 16); ticks(1, 16);
    chk("R6 constant low", tHi - h0, 0);
  endtask

  task automatic testShift();
    setCfg(2'd0, 9'd1, 3'b000);
    @(negedge clk); shiftLast = 1'b1; #1;
    chk("R7 last bit 1", int'(testPin), 1);
    @(negedge clk); shiftLast = 1'b0; #1;
    chk("R7 last bit 0", int'(testPin), 0);
  endtask

  task automatic testMain();
    int m0, f0, t0;
    freshCfg(2'd0, 9'd1, 3'b100);
    m0 = mis; f0 = fRise; ticks(0, 32);
    chk("R8 test copies main", mis - m0, 0);
    chk("R8 main rises", fRise - f0, 16);
    freshCfg(2'd0, 9'd1, 3'b111);
    f0 = fRise; t0 = tRise; ticks(0, 64);
    chk("R8 main div4 rises", tRise - t0, 8);
  endtask

  task automatic testBypass();
    int f0, t0;
    freshCfg(2'd1, 9'd5, 3'b110);
    f0 = fRise; t0 = tRise; ticks(0, 40);
    chk("R9 vco ignored main", fRise - f0, 0);
    chk("R9 vco ignored test", tRise - t0, 0);
    f0 = fRise; t0 = tRise; ticks(2, 60);
    chk("R9 serial div N", fRise - f0, 15);
    chk("R9 serial div M", tRise - t0, 12);
  endtask

  task automatic testNoSerial();
    int f0, t0;
    freshCfg(2'd0, 9'd3, 3'b011);
    f0 = fRise; t0 = tRise; ticks(2, 30);
    chk("R10 serial ignored main", fRise - f0, 0);
    chk("R10 serial ignored loop", tRise - t0, 0);
    f0 = fRise; t0 = tRise; ticks(0, 30);
    chk("R10 vco drives main", fRise - f0, 15);
    chk("R10 vco drives loop", tRise - t0, 10);
  endtask

  task automatic testRestart();
    int f0, t0;
    freshCfg(2'd3, 9'd7, 3'b011);
    ticks(0, 10);
    chk("R11 main high before change", int'(fOut), 1);
    @(negedge clk); nSel = 2'd0;
    @(posedge clk); #1;
    chk("R11 main low after N change", int'(fOut), 0);
    repeat (2) @(negedge clk); #1;
    f0 = fRise; ticks(0, 8);
    chk("R11 clean count after N change", fRise - f0, 4);
    freshCfg(2'd0, 9'd7, 3'b011);
    ticks(0, 5);
    setCfg(2'd0, 9'd4, 3'b011);
    t0 = tRise; ticks(0, 8);
    chk("R11 clean count after M change", tRise - t0, 2);
  endtask

  initial begin
    #(200000 * 5);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    testReset();
    @(negedge clk); rstN = 1'b1;
    repeat (2) @(negedge clk);
    testOutRatio();
    testLoop();
    testRef();
    testConst();
    testShift();
    testMain();
    testBypass();
    testNoSerial();
    testRestart();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule